// File: doc/BRIEF.md
# Serial Wire Debug Target Engine

This block is the target end of a two-wire serial debug link. The host supplies a debug clock, and the engine treats each clock as one bit slot. The bidirectional data line is split into three pins: the sampled line value, the value the engine drives, and an enable that says when it drives. The engine follows the line to detect a line reset and the idle period that must follow it. It collects 8-bit request packets and checks their framing and parity. If a request is valid, it answers with a 3-bit acknowledge. After that, it either returns a 33-bit read word or takes in a 33-bit write word. Between the two directions it leaves one slot in which neither side drives the line.

Behind the protocol logic is a small register bank. One debug-port address returns a fixed identification word. A second address returns a status word that holds a single sticky fault flag, which records a write with a corrupt data parity. The other addresses, in both the debug-port space and the access-port space, are plain scratch words. After each line reset the engine grants nothing but an identification read. Every other access is refused with a FAULT acknowledge until that read has been served.

Top module: `swd_target`

## Requirements
- R1: After the synchronous reset the engine does not drive the line. It then behaves as if a line reset had just occurred: access gating is active and an idle period is needed.
- R2: A line reset takes the engine to its reset state, stops it driving and re-arms the access gate. A line reset is 51 consecutive high samples, and 50 are not enough.
- R3: After a reset state the engine reacts to requests only once it has sampled two consecutive low slots.
- R4: Requests are sent bit 0 first. Bit 0 is a start bit of 1. Bit 1 selects the access-port space (1) or the debug-port space (0). Bit 2 is 1 for a read. Bits 3 and 4 carry register address bits 2 and 3. Bit 5 is even parity over bits 1 to 4. Bit 6 is a stop bit of 0. Bit 7 is a park bit seen as 1.
- R5: A request with a wrong parity, stop or park bit gets no response. The engine then ignores every request until the next line reset.
- R6: One turnaround slot follows each request. The acknowledge is then driven in 3 slots. OK is the sequence 1,0,0 and FAULT is the sequence 0,0,1. WAIT (0,1,0) is never produced.
- R7: Until a debug-port read of address 0 has been granted, every other access gets FAULT, then one turnaround slot, and no data phase. A refused write leaves the registers unchanged.
- R8: A debug-port read of address 0 returns 0x2BA01477.
- R9: A granted read has this slot order: acknowledge, turnaround, 32 data bits LSB first, an even parity bit, and a final turnaround.
- R10: A granted write has no turnaround after the acknowledge. The host sends 32 data bits LSB first in the next slots, followed by an even parity bit, and the word is stored.
- R11: The debug-port space has four addresses. Address 0 reads the ID word, and a write to it clears the fault flag. Address 1 reads the status word with the fault flag in bit 0, and writes to it are ignored. Addresses 2 and 3 are scratch words. All four access-port addresses are scratch words.
- R12: A write whose data parity is wrong is discarded and sets the fault flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Debug clock, one bit slot per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Sampled value of the data line |
| line_o | output | 1 | Value the engine drives onto the data line |
| line_oe | output | 1 | High while the engine drives the data line |

## Verification
If the slot counter is misaligned, the first granted transaction shows it within a single bit. The enable rises or falls one slot off the expected turnaround, or a read word comes back rotated and with the wrong parity. If the access gate or the lockout state is wrong, the engine gives a response where none is allowed, or gives OK where FAULT is required. That is visible in the acknowledge that follows the request. Corrupted bank contents or a wrong fault flag stay hidden until the host reads the word back, so each test that changes state is followed at once by a read of the affected address.

// File: rtl/swd_tgt_pkg.sv
package swd_tgt_pkg;

  typedef enum logic [3:0] {
    ST_RESET,
    ST_IDLE,
    ST_HDR,
    ST_TRN_REQ,
    ST_ACK,
    ST_TRN_ACK,
    ST_RDATA,
    ST_TRN_DAT,
    ST_WDATA,
    ST_LOCK
  } eng_state_e;

  // acknowledge words, bit 0 goes out first
  localparam logic [2:0] ACK_OK    = 3'b001;
  localparam logic [2:0] ACK_WAIT  = 3'b010;
  localparam logic [2:0] ACK_FAULT = 3'b100;

  typedef struct packed {
    logic       ap;
    logic       rd;
    logic [1:0] addr;
  } req_t;

  // framing check on a complete 8-bit request, bit 0 received first
  function automatic logic req_valid(input logic [7:0] h);
    return h[0] && ((^h[4:1]) == h[5]) && !h[6] && h[7];
  endfunction

endpackage

// File: rtl/swd_line_watch.sv
module swd_line_watch #(
  parameter int RESET_HIGH = 50,
  parameter int IDLE_LOW   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic line_rst,
  output logic idle_ok
);
  localparam int HW = $clog2(RESET_HIGH + 1);
  localparam int LW = $clog2(IDLE_LOW + 1);

  logic [HW-1:0] hi_cnt;
  logic [LW-1:0] lo_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
    end else if (line_i) begin
      lo_cnt <= '0;
      if (hi_cnt != HW'(RESET_HIGH)) hi_cnt <= hi_cnt + 1'b1;
    end else begin
      hi_cnt <= '0;
      if (lo_cnt != LW'(IDLE_LOW)) lo_cnt <= lo_cnt + 1'b1;
    end
  end

  // this sample is one more than the threshold of consecutive highs
  assign line_rst = line_i && (hi_cnt == HW'(RESET_HIGH));
  assign idle_ok  = !line_i && (lo_cnt >= LW'(IDLE_LOW - 1));

endmodule

// File: rtl/swd_reg_bank.sv
module swd_reg_bank #(
  parameter int          DW      = 32,
  parameter int          AW      = 2,
  parameter logic [31:0] ID_CODE = 32'h2BA01477
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          par_err,
  input  logic          ap,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 2 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] mem_q;
  logic          fault_flag;
  logic          sel_id_q, sel_stat_q;
  logic          dp_low;

  assign dp_low = !ap && (addr < AW'(2));

  // scratch storage: plain write port plus registered read
  always_ff @(posedge clk) begin
    if (wr_en && !dp_low) mem[{ap, addr}] <= wr_data;
    mem_q      <= mem[{ap, addr}];
    sel_id_q   <= !ap && (addr == AW'(0));
    sel_stat_q <= !ap && (addr == AW'(1));
  end

  always_ff @(posedge clk) begin
    if (rst)                                     fault_flag <= 1'b0;
    else if (par_err)                            fault_flag <= 1'b1;
    else if (wr_en && !ap && (addr == AW'(0)))   fault_flag <= 1'b0;
  end

  always_comb begin
    if (sel_id_q)        rd_data = DW'(ID_CODE);
    else if (sel_stat_q) rd_data = DW'(fault_flag);
    else                 rd_data = mem_q;
  end

endmodule

// File: rtl/swd_target.sv
module swd_target
  import swd_tgt_pkg::*;
#(
  parameter int          DW         = 32,
  parameter int          RESET_HIGH = 50,
  parameter int          IDLE_LOW   = 2,
  parameter logic [31:0] ID_CODE    = 32'h2BA01477
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic line_o,
  output logic line_oe
);
  localparam int CW = $clog2(DW + 2);

  eng_state_e      state;
  logic [CW-1:0]   cnt;
  logic [6:0]      hdr;
  req_t            req;
  logic [2:0]      ack_r;
  logic [DW:0]     sr;
  logic            id_ok;
  logic            line_rst, idle_ok;
  logic [7:0]      hdr_full;
  logic [DW:0]     wr_word;
  logic            wdat_last, wr_en, par_err, grant, is_id;
  logic [DW-1:0]   rd_data;

  swd_line_watch #(.RESET_HIGH(RESET_HIGH), .IDLE_LOW(IDLE_LOW)) watch_i (
    .clk(clk), .rst(rst), .line_i(line_i), .line_rst(line_rst), .idle_ok(idle_ok)
  );

  swd_reg_bank #(.DW(DW), .AW(2), .ID_CODE(ID_CODE)) bank_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .par_err(par_err), .ap(req.ap),
    .addr(req.addr), .wr_data(wr_word[DW-1:0]), .rd_data(rd_data)
  );

  always_comb begin
    hdr_full  = {line_i, hdr};
    wr_word   = {line_i, sr[DW:1]};
    wdat_last = (state == ST_WDATA) && (cnt == CW'(DW));
    wr_en     = wdat_last && ((^wr_word[DW-1:0]) == wr_word[DW]);
    par_err   = wdat_last && ((^wr_word[DW-1:0]) != wr_word[DW]);
    is_id     = !req.ap && req.rd && (req.addr == 2'd0);
    grant     = id_ok || is_id;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_RESET;
      cnt     <= '0;
      hdr     <= '0;
      req     <= '0;
      ack_r   <= '0;
      sr      <= '0;
      id_ok   <= 1'b0;
      line_o  <= 1'b0;
      line_oe <= 1'b0;
    end else if (line_rst) begin
      state   <= ST_RESET;
      line_oe <= 1'b0;
      id_ok   <= 1'b0;
    end else begin
      case (state)
        ST_RESET: if (idle_ok) state <= ST_IDLE;
        ST_IDLE: if (line_i) begin
          hdr   <= {1'b1, 6'b0};
          cnt   <= CW'(1);
          state <= ST_HDR;
        end
        ST_HDR: begin
          if (cnt == CW'(7)) begin
            if (req_valid(hdr_full)) begin
              req   <= '{ap: hdr_full[1], rd: hdr_full[2], addr: hdr_full[4:3]};
              state <= ST_TRN_REQ;
            end else begin
              state <= ST_LOCK;
            end
          end else begin
            hdr <= {line_i, hdr[6:1]};
            cnt <= cnt + 1'b1;
          end
        end
        ST_TRN_REQ: begin
          ack_r   <= grant ? ACK_OK : ACK_FAULT;
          line_o  <= grant;
          line_oe <= 1'b1;
          cnt     <= CW'(1);
          state   <= ST_ACK;
          if (is_id) id_ok <= 1'b1;
        end
        ST_ACK: begin
          if (cnt == CW'(3)) begin
            line_oe <= 1'b0;
            cnt     <= '0;
            state   <= (ack_r == ACK_OK && !req.rd) ? ST_WDATA : ST_TRN_ACK;
          end else begin
            line_o <= ack_r[cnt[1:0]];
            cnt    <= cnt + 1'b1;
          end
        end
        ST_TRN_ACK: begin
          if (ack_r != ACK_OK) begin
            state <= ST_IDLE;
          end else begin
            line_oe <= 1'b1;
            line_o  <= rd_data[0];
            sr      <= {1'b0, ^rd_data, rd_data[DW-1:1]};
            cnt     <= '0;
            state   <= ST_RDATA;
          end
        end
        ST_RDATA: begin
          if (cnt == CW'(DW)) begin
            line_oe <= 1'b0;
            state   <= ST_TRN_DAT;
          end else begin
            line_o <= sr[0];
            sr     <= {1'b0, sr[DW:1]};
            cnt    <= cnt + 1'b1;
          end
        end
        ST_TRN_DAT: state <= ST_IDLE;
        ST_WDATA: begin
          sr <= wr_word;
          if (cnt == CW'(DW)) state <= ST_IDLE;
          else                cnt   <= cnt + 1'b1;
        end
        ST_LOCK: state <= ST_LOCK;
        default: state <= ST_RESET;
      endcase
    end
  end

endmodule

// File: rtl/swd_target_chk.sv
module swd_target_chk
  import swd_tgt_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       line_oe,
  input logic       line_rst,
  input eng_state_e state,
  input logic       id_ok
);

  assert_quiet_after_reset_R1: assert property (@(posedge clk)
    rst |=> !line_oe);

  assert_line_reset_R2: assert property (@(posedge clk) disable iff (rst)
    line_rst |=> (state == ST_RESET && !line_oe));

  assert_lock_silent_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOCK) |-> !line_oe);

  assert_ack_driven_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ACK) |-> line_oe);

  assert_drive_after_trn_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(line_oe) |-> ($past(state) == ST_TRN_REQ || $past(state) == ST_TRN_ACK));

  assert_data_gated_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RDATA) |-> (id_ok && line_oe));

  assert_write_listen_R10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WDATA) |-> !line_oe);

endmodule

bind swd_target swd_target_chk chk_i (
  .clk(clk), .rst(rst), .line_oe(line_oe), .line_rst(line_rst),
  .state(state), .id_ok(id_ok)
);

// File: tb/swd_target_tb_top.sv
module swd_target_tb_top;
  localparam logic [31:0] ID = 32'h2BA01477;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic host_oe = 1'b1;
  logic host_bit = 1'b0;
  logic line_i, line_o, line_oe;

  // host drive wins; otherwise target drive; otherwise pull-up
  assign line_i = host_oe ? host_bit : (line_oe ? line_o : 1'b1);

  swd_target dut_i (.clk(clk), .rst(rst), .line_i(line_i), .line_o(line_o), .line_oe(line_oe));

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    int          len;
    logic [32:0] val;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [32:0] act, input logic [32:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // monitor: every run of driven slots is one response burst
  int          mon_n = 0;
  logic [32:0] mon_v = '0;
  exp_t        mon_e;
  always @(negedge clk) begin
    if (rst) begin
      mon_n = 0;
      mon_v = '0;
    end else if (line_oe) begin
      if (mon_n < 33) mon_v[mon_n] = line_o;
      mon_n++;
    end else if (mon_n > 0) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R5", "unexpected response burst", mon_v, '0);
      end else begin
        mon_e = exp_q.pop_front();
        check(mon_n == mon_e.len && mon_v == mon_e.val, mon_e.tag,
              $sformatf("response burst of %0d slots", mon_n), mon_v, mon_e.val);
      end
      mon_n = 0;
      mon_v = '0;
    end
  end

  task automatic expect_burst(input int len, input logic [32:0] v, input string tag);
    exp_t e;
    e.len = len; e.val = v; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic drive(input logic b);
    @(negedge clk); host_oe = 1'b1; host_bit = b;
  endtask

  task automatic rel();
    @(negedge clk); host_oe = 1'b0;
  endtask

  task automatic lows(input int n);
    for (int i = 0; i < n; i++) drive(1'b0);
  endtask

  task automatic highs(input int n);
    for (int i = 0; i < n; i++) drive(1'b1);
  endtask

  task automatic line_reset();
    highs(51); lows(2);
  endtask

  // slots 0..8: request then turnaround
  task automatic header(input bit ap, input bit rd, input logic [1:0] a,
                        input bit bad_par, input bit bad_stop, input bit bad_park);
    drive(1'b1); drive(ap); drive(rd); drive(a[0]); drive(a[1]);
    drive(ap ^ rd ^ a[0] ^ a[1] ^ bad_par);
    drive(bad_stop);
    if (bad_park) drive(1'b0); else rel();
    rel();
    check(line_oe == 1'b0, "R6", "line driven in request turnaround", line_oe, 0);
  endtask

  task automatic rd(input bit ap, input logic [1:0] a, input bit ok,
                    input logic [31:0] v, input string tag);
    expect_burst(3, ok ? 33'd1 : 33'd4, tag);
    if (ok) expect_burst(33, {^v, v}, tag);
    header(ap, 1'b1, a, 1'b0, 1'b0, 1'b0);
    rel();
    check(line_oe == 1'b1, "R6", "acknowledge not driven in slot 9", line_oe, 1);
    rel(); rel();
    rel();
    check(line_oe == 1'b0, ok ? "R9" : "R7", "turnaround after acknowledge", line_oe, 0);
    if (ok) begin
      rel();
      check(line_oe == 1'b1, "R9", "read data not driven in slot 13", line_oe, 1);
      for (int i = 14; i <= 45; i++) rel();
      rel();
      check(line_oe == 1'b0, "R9", "turnaround after read data", line_oe, 0);
    end
    lows(2);
  endtask

  task automatic wr(input bit ap, input logic [1:0] a, input bit ok,
                    input logic [31:0] v, input bit bad, input string tag);
    expect_burst(3, ok ? 33'd1 : 33'd4, tag);
    header(ap, 1'b0, a, 1'b0, 1'b0, 1'b0);
    rel();
    check(line_oe == 1'b1, "R6", "acknowledge not driven in slot 9", line_oe, 1);
    rel(); rel();
    if (ok) begin
      drive(v[0]);
      check(line_oe == 1'b0, "R10", "target drives in write data slot", line_oe, 0);
      for (int i = 1; i < 32; i++) drive(v[i]);
      drive((^v) ^ bad);
    end else begin
      rel();
      check(line_oe == 1'b0, "R7", "turnaround after FAULT", line_oe, 0);
    end
    lows(2);
  endtask

  task automatic silent(input bit ap, input bit rdn, input logic [1:0] a,
                        input bit bp, input bit bs, input bit bk, input string tag);
    int hits;
    hits = 0;
    header(ap, rdn, a, bp, bs, bk);
    for (int i = 0; i < 40; i++) begin
      drive(1'b0);
      if (line_oe) hits++;
    end
    check(hits == 0, tag, "response to a request that must be ignored", hits, 0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL R9 watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    check(line_oe == 1'b0, "R1", "line driven after reset", line_oe, 0);
    lows(3);

    // gate active straight after reset
    wr(1'b0, 2'd2, 1'b0, 32'h12345678, 1'b0, "R1");
    rd(1'b1, 2'd1, 1'b0, 32'h0, "R7");
    rd(1'b0, 2'd0, 1'b1, ID, "R8");

    // scratch words, both spaces
    wr(1'b0, 2'd2, 1'b1, 32'hA5A50F0F, 1'b0, "R10");
    wr(1'b1, 2'd0, 1'b1, 32'h01234567, 1'b0, "R10");
    wr(1'b1, 2'd3, 1'b1, 32'h89ABCDEF, 1'b0, "R10");
    wr(1'b1, 2'd1, 1'b1, 32'h0000FFFF, 1'b0, "R4");
    wr(1'b1, 2'd2, 1'b1, 32'hFFFF0000, 1'b0, "R4");
    wr(1'b0, 2'd3, 1'b1, 32'h5555AAAA, 1'b0, "R4");
    rd(1'b0, 2'd2, 1'b1, 32'hA5A50F0F, "R11");
    rd(1'b1, 2'd0, 1'b1, 32'h01234567, "R11");
    rd(1'b1, 2'd3, 1'b1, 32'h89ABCDEF, "R11");
    rd(1'b1, 2'd1, 1'b1, 32'h0000FFFF, "R4");
    rd(1'b1, 2'd2, 1'b1, 32'hFFFF0000, "R4");
    rd(1'b0, 2'd3, 1'b1, 32'h5555AAAA, "R4");

    // status word and ignored write
    rd(1'b0, 2'd1, 1'b1, 32'h0, "R11");
    wr(1'b0, 2'd1, 1'b1, 32'hFFFFFFFF, 1'b0, "R11");
    rd(1'b0, 2'd1, 1'b1, 32'h0, "R11");
    rd(1'b0, 2'd0, 1'b1, ID, "R8");

    // corrupt write data parity
    wr(1'b1, 2'd0, 1'b1, 32'hCAFEF00D, 1'b1, "R12");
    rd(1'b1, 2'd0, 1'b1, 32'h01234567, "R12");
    rd(1'b0, 2'd1, 1'b1, 32'h1, "R12");
    wr(1'b0, 2'd0, 1'b1, 32'h0, 1'b0, "R11");
    rd(1'b0, 2'd1, 1'b1, 32'h0, "R11");

    // line reset re-arms the gate; refused write changes nothing
    line_reset();
    rd(1'b1, 2'd3, 1'b0, 32'h0, "R2");
    wr(1'b1, 2'd3, 1'b0, 32'h0, 1'b0, "R7");
    rd(1'b0, 2'd0, 1'b1, ID, "R7");
    rd(1'b1, 2'd3, 1'b1, 32'h89ABCDEF, "R7");

    // 50 highs lock the engine without resetting it
    highs(50); lows(4);
    silent(1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, "R2");
    line_reset();
    rd(1'b0, 2'd0, 1'b1, ID, "R2");

    // only one low after line reset: no idle yet
    highs(51); lows(1);
    silent(1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, "R3");
    line_reset();
    rd(1'b0, 2'd0, 1'b1, ID, "R3");

    // malformed requests and lockout
    silent(1'b0, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, "R5");
    silent(1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, "R5");
    line_reset();
    silent(1'b0, 1'b1, 2'd0, 1'b0, 1'b1, 1'b0, "R5");
    line_reset();
    silent(1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1, "R4");
    line_reset();
    rd(1'b0, 2'd0, 1'b1, ID, "R5");

    lows(3);
    check(exp_q.size() == 0, "R9", "expected responses never seen", exp_q.size(), 0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule